// File: doc/BRIEF.md
# Cache Line Fault Retirement Controller

This block tracks recurring correctable errors in a set-associative cache and takes lines out of service once their faults look permanent. Each report names a set and a way. The block counts errors separately for every line. Errors below the threshold are left to the ECC path and cause no visible change.

When a line reaches the threshold it is retired, and the block emits a one-cycle directory invalidate for that set and way. If a spare line is free, the lowest free spare takes over the line, and the lookup port redirects later accesses to that spare. If no spare is free, the line is deleted: its way is removed from the allocation mask and the lookup port reports it unusable. The sets are split into four quarters by the top two bits of the set index. Once a configurable number of lines in one quarter have been deleted, the whole quarter is removed from service and a per-quarter status bit is raised.

Top module: `cache_fault_mgr`

## Requirements
- R1: After reset, every way of every set is allocatable and reported usable. No line is remapped, all quarter flags are 0, and `spares_left` equals SPARES.
- R2: Errors on a line below the threshold (THRESH, default 3) do not change the lookup, allocation, invalidate or status outputs.
- R3: The THRESH-th error on a line, when a spare is free, assigns the lowest-numbered free spare. From the next cycle, the lookup for that set and way gives `lk_spared`=1 and that spare's number, the line stays allocatable, and `spares_left` drops by one.
- R4: An error increments only the counter of the reported set and way. Errors on other lines do not move a line nearer its threshold.
- R5: The THRESH-th error on a line, when no spare is free, deletes the line. From the next cycle its bit in `alloc_mask` is 0 and its lookup gives `lk_ok`=0.
- R6: In the cycle after a retiring report, `inval_valid` is 1 and `inval_set`/`inval_way` carry the retired line. At all other times `inval_valid` is 0.
- R7: When the number of deleted lines in one quarter reaches QDEL_LIMIT (default 2), that quarter's `q_dead` bit goes to 1 in the next cycle. From then on, every way of every set in the quarter has `alloc_mask` 0 and `lk_ok` 0.
- R8: A report on a line that is already spared, already deleted, or in a dead quarter is ignored. It assigns no spare, raises no invalidate, and changes no output.
- R9: Set s belongs to quarter s[SW-1:SW-2], where SW is the set index width. `q_dead` bit q corresponds to quarter q. Sets outside a dead quarter keep their allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Correctable error report strobe |
| err_set | input | SW | Set of reported line |
| err_way | input | WW | Way of reported line |
| lk_set | input | SW | Lookup set |
| lk_way | input | WW | Lookup way |
| lk_ok | output | 1 | Looked-up line is usable |
| lk_spared | output | 1 | Looked-up line is redirected to a spare |
| lk_spare_id | output | SPW | Spare serving the looked-up line |
| alloc_set | input | SW | Set whose allocation mask is requested |
| alloc_mask | output | WAYS | Ways of `alloc_set` that may be allocated |
| inval_valid | output | 1 | Directory invalidate pulse |
| inval_set | output | SW | Set to invalidate |
| inval_way | output | WW | Way to invalidate |
| q_dead | output | 4 | Per-quarter deletion flags |
| spares_left | output | SLW | Number of unassigned spares |

## Verification
Every retirement decision is registered on the edge that captures the report. The bench drives a report on a falling edge and reads the invalidate pulse at the following falling edge, where the registered state is also visible. The lookup and allocation ports are combinational over that state. Once a report has been taken, the bench walks all sets and ways through those ports, leaving 1 ns after each change, and compares the results against a model kept from the requirements.

// File: rtl/cache_fault_mgr.sv
module cache_fault_mgr #(
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int THRESH     = 3,
  parameter int SPARES     = 2,
  parameter int QDEL_LIMIT = 2,
  localparam int SW    = $clog2(SETS),
  localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SPW   = (SPARES > 1) ? $clog2(SPARES) : 1,
  localparam int SLW   = $clog2(SPARES + 1),
  localparam int LINES = SETS * WAYS,
  localparam int LW    = SW + WW,
  localparam int CW    = $clog2(THRESH + 1),
  localparam int QCW   = $clog2(QDEL_LIMIT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            err_valid,
  input  logic [SW-1:0]   err_set,
  input  logic [WW-1:0]   err_way,
  input  logic [SW-1:0]   lk_set,
  input  logic [WW-1:0]   lk_way,
  output logic            lk_ok,
  output logic            lk_spared,
  output logic [SPW-1:0]  lk_spare_id,
  input  logic [SW-1:0]   alloc_set,
  output logic [WAYS-1:0] alloc_mask,
  output logic            inval_valid,
  output logic [SW-1:0]   inval_set,
  output logic [WW-1:0]   inval_way,
  output logic [3:0]      q_dead,
  output logic [SLW-1:0]  spares_left
);

  logic [CW-1:0]  cnt [LINES];
  logic [LINES-1:0] deleted, spared;
  logic [SPARES-1:0] sp_used;
  logic [LW-1:0]  sp_line [SPARES];
  logic [QCW-1:0] qdel [4];

  wire [LW-1:0] e_line = {err_set, err_way};
  wire [1:0]    e_q    = err_set[SW-1 -: 2];
  wire e_retired = deleted[e_line] | spared[e_line] | q_dead[e_q];
  wire e_hit     = err_valid & ~e_retired;
  wire e_trip    = e_hit & (cnt[e_line] == CW'(THRESH - 1));

  logic           free_ok;
  logic [SPW-1:0] free_id;
  always_comb begin
    free_ok = 1'b0;
    free_id = '0;
    for (int i = SPARES - 1; i >= 0; i--)
      if (!sp_used[i]) begin
        free_ok = 1'b1;
        free_id = SPW'(i);
      end
  end

  always_comb begin
    spares_left = SLW'(SPARES);
    for (int i = 0; i < SPARES; i++)
      if (sp_used[i]) spares_left = spares_left - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) cnt[i] <= '0;
      for (int i = 0; i < SPARES; i++) sp_line[i] <= '0;
      for (int q = 0; q < 4; q++) qdel[q] <= '0;
      deleted     <= '0;
      spared      <= '0;
      sp_used     <= '0;
      q_dead      <= '0;
      inval_valid <= 1'b0;
      inval_set   <= '0;
      inval_way   <= '0;
    end else begin
      inval_valid <= e_trip;
      if (e_trip) begin
        inval_set <= err_set;
        inval_way <= err_way;
      end
      if (e_hit) cnt[e_line] <= cnt[e_line] + 1'b1;
      if (e_trip) begin
        if (free_ok) begin
          sp_used[free_id] <= 1'b1;
          sp_line[free_id] <= e_line;
          spared[e_line]   <= 1'b1;
        end else begin
          deleted[e_line] <= 1'b1;
          qdel[e_q]       <= qdel[e_q] + 1'b1;
          if (qdel[e_q] == QCW'(QDEL_LIMIT - 1)) q_dead[e_q] <= 1'b1;
        end
      end
    end
  end

  wire [LW-1:0] l_line = {lk_set, lk_way};
  wire [1:0]    l_q    = lk_set[SW-1 -: 2];
  logic [SPARES-1:0] l_match;

  always_comb begin
    lk_spare_id = '0;
    for (int i = 0; i < SPARES; i++) begin
      l_match[i] = sp_used[i] && (sp_line[i] == l_line);
      if (l_match[i]) lk_spare_id = SPW'(i);
    end
  end

  assign lk_spared = spared[l_line];
  assign lk_ok     = ~deleted[l_line] & ~q_dead[l_q];

  wire [1:0] a_q = alloc_set[SW-1 -: 2];
  for (genvar w = 0; w < WAYS; w++) begin : g_alloc
    assign alloc_mask[w] = ~deleted[{alloc_set, WW'(w)}] & ~q_dead[a_q];
  end

  AST_SPARES_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    spares_left <= $past(spares_left)); // R3
  AST_SPARE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_match)); // R3
  AST_SPARE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    lk_spared == (l_match != '0)); // R3
  AST_DEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (deleted & $past(deleted)) == $past(deleted)); // R5
  AST_INVAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |-> $past(err_valid)); // R6
  AST_QDEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_dead & $past(q_dead)) == $past(q_dead)); // R7
  AST_RETIRED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && e_retired) |=> (!inval_valid && $stable(spares_left))); // R8

endmodule

// File: tb/test_cache_fault_mgr.sv
`timescale 1ns/1ps
module test_cache_fault_mgr;
  localparam int SETS = 16, WAYS = 4, THRESH = 3, SPARES = 2, QL = 2;

  logic clk = 0, rst_n = 0;
  logic err_valid = 0;
  logic [3:0] err_set = 0, lk_set = 0, alloc_set = 0;
  logic [1:0] err_way = 0, lk_way = 0;
  logic lk_ok, lk_spared, inval_valid;
  logic [0:0] lk_spare_id;
  logic [3:0] alloc_mask, inval_set, q_dead;
  logic [1:0] inval_way, spares_left;

  int total = 0, bad = 0;
  int m_cnt [64];
  int m_sp  [64];
  bit m_del [64];
  int m_qd  [4];
  bit m_qx  [4];
  int m_used;
  bit exp_inv;
  int exp_is, exp_iw;

  always #2.5 clk = ~clk;

  cache_fault_mgr #(.SETS(SETS), .WAYS(WAYS), .THRESH(THRESH), .SPARES(SPARES),
                    .QDEL_LIMIT(QL)) i_cache_fault_mgr (
    .clk, .rst_n, .err_valid, .err_set, .err_way, .lk_set, .lk_way, .lk_ok,
    .lk_spared, .lk_spare_id, .alloc_set, .alloc_mask, .inval_valid,
    .inval_set, .inval_way, .q_dead, .spares_left);

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic sweep(input string tag);
    int qv;
    qv = 0;
    for (int q = 0; q < 4; q++) qv |= int'(m_qx[q]) << q;
    chk({tag, " q_dead"}, q_dead, qv);
    chk({tag, " spares_left"}, spares_left, SPARES - m_used);
    for (int s = 0; s < SETS; s++) begin
      int am;
      am = 0;
      for (int w = 0; w < WAYS; w++) begin
        int l;
        bit ok;
        l = s * WAYS + w;
        ok = !m_del[l] && !m_qx[s / 4];
        am |= int'(ok) << w;
        lk_set = s[3:0];
        lk_way = w[1:0];
        #1;
        chk({tag, " lk_ok"}, lk_ok, ok);
        chk({tag, " lk_spared"}, lk_spared, m_sp[l] >= 0);
        if (m_sp[l] >= 0) chk({tag, " lk_spare_id"}, lk_spare_id, m_sp[l]);
      end
      alloc_set = s[3:0];
      #1;
      chk({tag, " alloc_mask"}, alloc_mask, am);
    end
  endtask

  task automatic report(input int s, input int w);
    int l;
    l = s * WAYS + w;
    exp_inv = 0;
    if (!m_del[l] && m_sp[l] < 0 && !m_qx[s / 4]) begin
      m_cnt[l]++;
      if (m_cnt[l] == THRESH) begin
        exp_inv = 1;
        exp_is = s;
        exp_iw = w;
        if (m_used < SPARES) begin
          m_sp[l] = m_used;
          m_used++;
        end else begin
          m_del[l] = 1;
          m_qd[s / 4]++;
          if (m_qd[s / 4] == QL) m_qx[s / 4] = 1;
        end
      end
    end
    @(negedge clk);
    err_valid = 1;
    err_set = s[3:0];
    err_way = w[1:0];
    @(negedge clk);
    err_valid = 0;
    chk("R6 inval_valid", inval_valid, exp_inv);
    if (exp_inv) begin
      chk("R6 inval_set", inval_set, exp_is);
      chk("R6 inval_way", inval_way, exp_iw);
    end
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog got=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_cnt[i] = 0; m_sp[i] = -1; m_del[i] = 0; end
    for (int q = 0; q < 4; q++) begin m_qd[q] = 0; m_qx[q] = 0; end
    m_used = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 inval_valid", inval_valid, 0);
    sweep("R1");
    report(1, 0); report(1, 0);
    sweep("R2");
    report(2, 1);
    report(6, 3); report(6, 3);
    sweep("R4");
    report(1, 0);
    sweep("R3 first spare");
    report(1, 0); report(1, 0);
    sweep("R8 spared line");
    report(5, 2); report(5, 2); report(5, 2);
    sweep("R3 second spare");
    report(0, 3); report(0, 3); report(0, 3);
    sweep("R5");
    report(0, 3);
    sweep("R8 deleted line");
    report(2, 1); report(2, 1);
    sweep("R7");
    report(3, 3); report(3, 3); report(3, 3);
    sweep("R8 dead quarter");
    report(12, 0); report(12, 0); report(12, 0);
    sweep("R9");
    report(6, 3);
    sweep("R5 second quarter");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule